// File: doc/BRIEF.md
# Peripheral Bus Command Engine

This block runs one register-level transaction on a peripheral bus, on behalf of a local requester. A request gives a transaction kind (read, write or a control command without data), the bus opcode, a 4-bit target ID, a 16-bit register address, a length written as bytes minus one, and up to eight write bytes. The engine checks the request and maps the bus opcode onto a 5-bit internal command code. It then packs a 32-bit command word in one of two layouts, chosen by the `fmt_v2` input.

Once a request passes its checks, the engine drives a small register port that faces the bus serializer. For writes it first stores the data words and then writes the command word. It then polls the serializer's status register at a fixed interval, up to a limit. When the status shows a clean completion of a read, it fetches the read data words. The requester receives one response pulse. The pulse carries a 3-bit result code and the read bytes.

Top module: `bus_cmd_engine`

## Requirements
- R1: A read or write whose length field `req_cnt` (bytes minus one) is 8 or above completes with result 1 (invalid). Such a request causes no access on the bus port, and `resp_valid` rises in the cycle after acceptance.
- R2: Read opcodes map as follows: 0x20–0x2F gives code 13, 0x38–0x3F gives code 1, and 0x60–0x7F gives code 15. Any other read opcode gives result 1 with no bus access.
- R3: Write opcodes map as follows: 0x00–0x0F gives code 2, 0x30–0x37 gives code 0, 0x40–0x5F gives code 14, and 0x80–0xFF gives code 16. Any other write opcode gives result 1 with no bus access.
- R4: With `fmt_v2`=0, a data command word holds the code in bits 31:27, the target ID in bits 23:20, the full address in bits 19:4 and `req_cnt[2:0]` in bits 2:0. All other bits are zero.
- R5: With `fmt_v2`=1, the command word holds the code in bits 31:27, address[7:0] in bits 11:4 and `req_cnt[2:0]` in bits 2:0. All other bits are zero, so the target ID is left out.
- R6: A control request (kind 2) with opcode 0x10–0x13 has a format-1 word made only of opcode[4:0] in bits 31:27 and the target ID in bits 23:20. In format 2 the same request returns result 5 (unsupported) with no bus access. A control request with any other opcode, and any request of kind 3, returns result 1.
- R7: Data bytes are packed little-endian: bytes 0–3 go to data word 0 (byte 0 in bits 7:0), and bytes 4–7 go to data word 1. Word 1 is transferred only when `req_cnt` > 3. Bytes beyond the length are zero, both in the written words and in `resp_rdata`.
- R8: A write stores its data words on the bus port before the command word. A read fetches data words only after a poll that saw done set with no error bits.
- R9: The status bits are: bit 0 done, bit 1 failure, bit 2 denied, bit 3 dropped. When done is seen, the result is 2 if denied is set. Otherwise it is 3 if failure or dropped is set, and 0 if none of them is set.
- R10: The first status poll falls in the cycle after the command word. Later polls follow every `POLL_GAP` cycles, for at most `MAX_POLLS` polls in total. Error bits are ignored while done is clear. If no poll sees done, the result is 4 (timeout).
- R11: `req_ready` is high only while the engine is idle. It is high after reset. `resp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_v2 | input | 1 | Command word layout select (0: format 1, 1: format 2) |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request accepted when valid |
| req_kind | input | 2 | 0 read, 1 write, 2 control, 3 reserved |
| req_opcode | input | 8 | Bus opcode |
| req_sid | input | 4 | Target ID |
| req_addr | input | 16 | Register address |
| req_cnt | input | 4 | Length in bytes minus one |
| req_wdata | input | 64 | Write bytes, byte 0 in bits 7:0 |
| resp_valid | output | 1 | Response pulse |
| resp_err | output | 3 | 0 ok, 1 invalid, 2 denied, 3 I/O error, 4 timeout, 5 unsupported |
| resp_rdata | output | 64 | Read bytes, zero above the length |
| bus_we | output | 1 | Register write strobe toward the serializer |
| bus_re | output | 1 | Register read strobe toward the serializer |
| bus_sel | output | 3 | Register select: 0 command, 1 data out 0, 2 data out 1, 3 data in 0, 4 data in 1, 5 status |
| bus_wdata | output | 32 | Write value |
| bus_rdata | input | 32 | Read value, combinational for the selected register |

## Verification
A rejected request must raise `resp_valid` one cycle after acceptance, and the bench expects that request to leave the bus port untouched. For issued commands the bench records the cycle of the command word. The poll that first sees done is poll j = ceil(delay / `POLL_GAP`). The response is due 2 + j·`POLL_GAP` cycles after the command word, plus one or two cycles for the fetch of read words; on a timeout it is due 2 + (`MAX_POLLS`−1)·`POLL_GAP` cycles after the command word. The bench compares the recorded distance with that figure, and it checks the order of the data and command strobes against the cycles in which it saw them.

// File: rtl/bce_pkg.sv
// Package: shared encodings for the bus command engine.
// Assumes a 32-bit register port and at most eight data bytes per transfer.
package bce_pkg;
    localparam int WORD_W     = 32;
    localparam int DATA_BYTES = 8;
    localparam int DATA_W     = DATA_BYTES * 8;
    localparam int CODE_W     = 5;
    localparam int CODE_LSB   = 27;
    localparam int SID_LSB    = 20;
    localparam int ADDR_LSB   = 4;
    localparam int SID_W      = 4;
    localparam int ADDR_W     = 16;

    // status bit positions
    localparam int ST_DONE = 0;
    localparam int ST_FAIL = 1;
    localparam int ST_DENY = 2;
    localparam int ST_DROP = 3;

    localparam logic [1:0] KIND_READ  = 2'd0;
    localparam logic [1:0] KIND_WRITE = 2'd1;
    localparam logic [1:0] KIND_CTRL  = 2'd2;

    localparam logic [2:0] RES_OK      = 3'd0;
    localparam logic [2:0] RES_INVALID = 3'd1;
    localparam logic [2:0] RES_DENIED  = 3'd2;
    localparam logic [2:0] RES_IO      = 3'd3;
    localparam logic [2:0] RES_TIMEOUT = 3'd4;
    localparam logic [2:0] RES_UNSUPP  = 3'd5;

    localparam logic [2:0] SEL_CMD    = 3'd0;
    localparam logic [2:0] SEL_DOUT0  = 3'd1;
    localparam logic [2:0] SEL_DOUT1  = 3'd2;
    localparam logic [2:0] SEL_DIN0   = 3'd3;
    localparam logic [2:0] SEL_DIN1   = 3'd4;
    localparam logic [2:0] SEL_STATUS = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR0, ST_WR1, ST_ISSUE, ST_POLL, ST_RD0, ST_RD1, ST_RESP
    } eng_state_e;
endpackage

// File: rtl/bce_xlate.sv
// Request checker and opcode mapper (combinational).
// Maps a bus opcode onto the internal 5-bit code and flags invalid or
// unsupported requests. Assumes the length field is bytes minus one.
module bce_xlate
    import bce_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [7:0]        opcode,
    input  logic [3:0]        cnt,
    input  logic              fmt_v2,
    output logic [CODE_W-1:0] code,
    output logic [2:0]        result
);
    // Purpose: range decode of the opcode per kind, then the length check.
    always_comb begin
        code   = '0;
        result = RES_OK;
        case (kind)
            KIND_READ: begin
                if (opcode inside {[8'h60:8'h7F]})      code = 5'd15;
                else if (opcode inside {[8'h20:8'h2F]}) code = 5'd13;
                else if (opcode inside {[8'h38:8'h3F]}) code = 5'd1;
                else                                    result = RES_INVALID;
            end
            KIND_WRITE: begin
                if (opcode inside {[8'h40:8'h5F]})      code = 5'd14;
                else if (opcode inside {[8'h00:8'h0F]}) code = 5'd2;
                else if (opcode inside {[8'h30:8'h37]}) code = 5'd0;
                else if (opcode[7])                     code = 5'd16;
                else                                    result = RES_INVALID;
            end
            KIND_CTRL: begin
                if (opcode inside {[8'h10:8'h13]}) begin
                    code = opcode[CODE_W-1:0];
                    if (fmt_v2) result = RES_UNSUPP;
                end else begin
                    result = RES_INVALID;
                end
            end
            default: result = RES_INVALID;
        endcase
        if (kind != KIND_CTRL && cnt[3]) result = RES_INVALID;
    end
endmodule

// File: rtl/bce_pack.sv
// Command word formatter (combinational).
// Builds the 32-bit command word in format 1 or 2. Control commands carry
// only the code and target ID. Assumes the code is already mapped.
module bce_pack
    import bce_pkg::*;
(
    input  logic              fmt_v2,
    input  logic              is_ctrl,
    input  logic [CODE_W-1:0] code,
    input  logic [SID_W-1:0]  sid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        cnt,
    output logic [WORD_W-1:0] word
);
    // Purpose: place each field at its position for the selected layout.
    always_comb begin
        word = '0;
        word[CODE_LSB +: CODE_W] = code;
        if (!fmt_v2) begin
            word[SID_LSB +: SID_W] = sid;
            if (!is_ctrl) begin
                word[ADDR_LSB +: ADDR_W] = addr;
                word[2:0]                = cnt;
            end
        end else begin
            word[ADDR_LSB +: 8] = addr[7:0];
            word[2:0]           = cnt;
        end
    end
endmodule

// File: rtl/bce_status.sv
// Completion status decoder (combinational).
// Reports done and ranks the error bits: denied, then failure, then dropped.
// The caller uses the result only when done is set.
module bce_status
    import bce_pkg::*;
(
    input  logic [3:0] stat,
    output logic       done,
    output logic [2:0] result
);
    // Purpose: fixed-priority error ranking.
    always_comb begin
        done = stat[ST_DONE];
        if (stat[ST_DENY])                      result = RES_DENIED;
        else if (stat[ST_FAIL] || stat[ST_DROP]) result = RES_IO;
        else                                    result = RES_OK;
    end
endmodule

// File: rtl/bce_poller.sv
// Bounded poll pacer.
// After start, it flags a sample slot at once and then every POLL_GAP
// cycles while the caller asks to advance. It reports the last allowed poll.
// Assumes MAX_POLLS >= 2 and POLL_GAP >= 1.
module bce_poller #(
    parameter int MAX_POLLS = 100,
    parameter int POLL_GAP  = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic active,
    input  logic advance,
    output logic sample,
    output logic last
);
    localparam int PCNT_W = $clog2(MAX_POLLS);
    localparam int GCNT_W = $clog2(POLL_GAP + 1);
    localparam logic [PCNT_W-1:0] PCNT_LAST = PCNT_W'(MAX_POLLS - 1);
    localparam logic [GCNT_W-1:0] GAP_LOAD  = GCNT_W'(POLL_GAP - 1);

    logic [PCNT_W-1:0] poll_cnt;
    logic [GCNT_W-1:0] gap_cnt;

    assign sample = active && (gap_cnt == '0);
    assign last   = (poll_cnt == PCNT_LAST);

    // Purpose: count down the gap between polls and count polls taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else if (start) begin
            poll_cnt <= '0;
            gap_cnt  <= '0;
        end else if (active) begin
            if (gap_cnt != '0) begin
                gap_cnt <= gap_cnt - 1'b1;
            end else if (advance && !last) begin
                gap_cnt  <= GAP_LOAD;
                poll_cnt <= poll_cnt + 1'b1;
            end
        end
    end

    // R10
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        poll_cnt <= PCNT_LAST);

    // R10
    poll_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && advance && !last && !start) |=> (gap_cnt == GAP_LOAD || POLL_GAP == 1));
endmodule

// File: rtl/bus_cmd_engine.sv
// Bus command issue and completion engine (top).
// Accepts one request, checks it, writes data and command words to the
// serializer register port, polls status with a bounded count, fetches read
// words, and returns one response pulse. Assumes bus_rdata is valid in the
// same cycle as bus_re and bus_sel.
module bus_cmd_engine
    import bce_pkg::*;
#(
    parameter int MAX_POLLS = 100,
    parameter int POLL_GAP  = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fmt_v2,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_kind,
    input  logic [7:0]  req_opcode,
    input  logic [3:0]  req_sid,
    input  logic [15:0] req_addr,
    input  logic [3:0]  req_cnt,
    input  logic [63:0] req_wdata,
    output logic        resp_valid,
    output logic [2:0]  resp_err,
    output logic [63:0] resp_rdata,
    output logic        bus_we,
    output logic        bus_re,
    output logic [2:0]  bus_sel,
    output logic [31:0] bus_wdata,
    input  logic [31:0] bus_rdata
);
    localparam int HALF_W = DATA_W / 2;

    eng_state_e        state;
    logic [1:0]        kind_q;
    logic [2:0]        cnt_q;
    logic [WORD_W-1:0] cmd_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [2:0]        res_q;

    logic [CODE_W-1:0] xl_code;
    logic [2:0]        xl_res;
    logic [WORD_W-1:0] pk_word;
    logic              st_done;
    logic [2:0]        st_res;
    logic              pl_sample, pl_last;
    logic [DATA_W-1:0] wr_masked;
    logic [DATA_W-1:0] rd_mask;
    logic              accept;
    logic              long_q;

    assign accept = req_valid && req_ready;
    assign long_q = (cnt_q > 3'd3);

    bce_xlate u_xlate (
        .kind   (req_kind),
        .opcode (req_opcode),
        .cnt    (req_cnt),
        .fmt_v2 (fmt_v2),
        .code   (xl_code),
        .result (xl_res)
    );

    bce_pack u_pack (
        .fmt_v2  (fmt_v2),
        .is_ctrl (req_kind == KIND_CTRL),
        .code    (xl_code),
        .sid     (req_sid),
        .addr    (req_addr),
        .cnt     (req_cnt[2:0]),
        .word    (pk_word)
    );

    bce_status u_status (
        .stat   (bus_rdata[3:0]),
        .done   (st_done),
        .result (st_res)
    );

    bce_poller #(.MAX_POLLS(MAX_POLLS), .POLL_GAP(POLL_GAP)) u_poller (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (state == ST_ISSUE),
        .active  (state == ST_POLL),
        .advance (!st_done),
        .sample  (pl_sample),
        .last    (pl_last)
    );

    // Per-byte keep masks: request length for writes, stored length for reads.
    for (genvar b = 0; b < DATA_BYTES; b++) begin : g_byte
        localparam logic [2:0] BIDX = 3'(b);
        assign wr_masked[b*8 +: 8] = (BIDX <= req_cnt[2:0]) ? req_wdata[b*8 +: 8] : 8'h00;
        assign rd_mask[b*8 +: 8]   = {8{BIDX <= cnt_q}};
    end

    // Purpose: transaction sequencer and request/response registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            kind_q  <= '0;
            cnt_q   <= '0;
            cmd_q   <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            res_q   <= RES_OK;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    kind_q  <= req_kind;
                    cnt_q   <= req_cnt[2:0];
                    cmd_q   <= pk_word;
                    wdata_q <= wr_masked;
                    rdata_q <= '0;
                    res_q   <= xl_res;
                    if (xl_res != RES_OK)           state <= ST_RESP;
                    else if (req_kind == KIND_WRITE) state <= ST_WR0;
                    else                             state <= ST_ISSUE;
                end
                ST_WR0:   state <= long_q ? ST_WR1 : ST_ISSUE;
                ST_WR1:   state <= ST_ISSUE;
                ST_ISSUE: state <= ST_POLL;
                ST_POLL: if (pl_sample) begin
                    if (st_done) begin
                        res_q <= st_res;
                        if (st_res == RES_OK && kind_q == KIND_READ) state <= ST_RD0;
                        else                                         state <= ST_RESP;
                    end else if (pl_last) begin
                        res_q <= RES_TIMEOUT;
                        state <= ST_RESP;
                    end
                end
                ST_RD0: begin
                    rdata_q[HALF_W-1:0] <= bus_rdata & rd_mask[HALF_W-1:0];
                    state <= long_q ? ST_RD1 : ST_RESP;
                end
                ST_RD1: begin
                    rdata_q[DATA_W-1:HALF_W] <= bus_rdata & rd_mask[DATA_W-1:HALF_W];
                    state <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: register-port strobes and select from the current state.
    always_comb begin
        bus_we    = 1'b0;
        bus_re    = 1'b0;
        bus_sel   = SEL_CMD;
        bus_wdata = '0;
        case (state)
            ST_WR0:   begin bus_we = 1'b1; bus_sel = SEL_DOUT0; bus_wdata = wdata_q[HALF_W-1:0]; end
            ST_WR1:   begin bus_we = 1'b1; bus_sel = SEL_DOUT1; bus_wdata = wdata_q[DATA_W-1:HALF_W]; end
            ST_ISSUE: begin bus_we = 1'b1; bus_sel = SEL_CMD;   bus_wdata = cmd_q; end
            ST_POLL:  begin bus_re = pl_sample; bus_sel = SEL_STATUS; end
            ST_RD0:   begin bus_re = 1'b1; bus_sel = SEL_DIN0; end
            ST_RD1:   begin bus_re = 1'b1; bus_sel = SEL_DIN1; end
            default:  ;
        endcase
    end

    assign req_ready  = (state == ST_IDLE);
    assign resp_valid = (state == ST_RESP);
    assign resp_err   = res_q;
    assign resp_rdata = rdata_q;

    // R11
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !req_ready);

    // R1
    reject_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_err == RES_INVALID || resp_err == RES_UNSUPP)) |-> $past(accept));

    // R8
    data_before_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_sel == SEL_CMD && kind_q == KIND_WRITE)
            |-> $past(bus_we && (bus_sel == SEL_DOUT0 || bus_sel == SEL_DOUT1)));

    // R8
    read_after_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_sel == SEL_DIN0)
            |-> $past(bus_re && bus_sel == SEL_STATUS && bus_rdata[3:0] == 4'b0001));

    // R9
    deny_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_sel == SEL_STATUS && bus_rdata[ST_DONE] && bus_rdata[ST_DENY])
            |=> (resp_valid && resp_err == RES_DENIED));

    // R8
    port_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));
endmodule

// File: tb/bus_cmd_engine_bench.sv
// Bench: sweeps opcodes, lengths, layouts, status values and completion delays,
// with a serializer model that sets done a programmed number of cycles after
// the command word.
module bus_cmd_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 3;
    localparam int POLLS      = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_v2 = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [7:0]  req_opcode = '0;
    logic [3:0]  req_sid = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_cnt = '0;
    logic [63:0] req_wdata = '0;
    logic        resp_valid;
    logic [2:0]  resp_err;
    logic [63:0] resp_rdata;
    logic        bus_we, bus_re;
    logic [2:0]  bus_sel;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cmd_engine #(.MAX_POLLS(POLLS), .POLL_GAP(GAP)) u_bus_cmd_engine (
        .clk(clk), .rst_n(rst_n), .fmt_v2(fmt_v2),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_opcode(req_opcode), .req_sid(req_sid), .req_addr(req_addr),
        .req_cnt(req_cnt), .req_wdata(req_wdata),
        .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // serializer model
    int          rsp_delay = 0;
    logic [2:0]  rsp_ebits = '0;   // {dropped, denied, failure}
    logic [31:0] rsp_rd0 = '0, rsp_rd1 = '0;
    logic        busy;
    int          rem;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; rem <= 0;
        end else if (req_valid && req_ready) begin
            busy <= 1'b0;
        end else if (bus_we && bus_sel == 3'd0) begin
            busy <= 1'b1; rem <= rsp_delay;
        end else if (rem > 0) begin
            rem <= rem - 1;
        end
    end

    always_comb begin
        case (bus_sel)
            3'd3:    bus_rdata = rsp_rd0;
            3'd4:    bus_rdata = rsp_rd1;
            3'd5:    bus_rdata = {28'd0, rsp_ebits, busy && rem == 0};
            default: bus_rdata = 32'hDEAD_BEEF;
        endcase
    end

    // monitor, sampled at the falling edge
    int n_cmd = 0, n_wd0 = 0, n_wd1 = 0, n_rd0 = 0, n_rd1 = 0, n_st = 0, n_resp = 0;
    int cyc = 0, cmd_cyc = 0, wd_cyc = 0, rd0_cyc = 0, resp_cyc = 0;
    logic [31:0] cmd_word, wd0, wd1;
    logic [2:0]  resp_e;
    logic [63:0] resp_d;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (bus_we) begin
            case (bus_sel)
                3'd0: begin n_cmd++; cmd_word = bus_wdata; cmd_cyc = cyc; end
                3'd1: begin n_wd0++; wd0 = bus_wdata; wd_cyc = cyc; end
                3'd2: begin n_wd1++; wd1 = bus_wdata; wd_cyc = cyc; end
                default: ;
            endcase
        end
        if (bus_re) begin
            case (bus_sel)
                3'd3: begin n_rd0++; rd0_cyc = cyc; end
                3'd4: n_rd1++;
                3'd5: n_st++;
                default: ;
            endcase
        end
        if (resp_valid) begin
            n_resp++; resp_cyc = cyc; resp_e = resp_err; resp_d = resp_rdata;
        end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] keep_bytes(input logic [63:0] d, input int cnt);
        logic [63:0] r = '0;
        for (int b = 0; b < 8; b++) if (b <= cnt) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    // expected mapping per R2, R3, R6, R1
    task automatic expect_req(input int kind, input int op, input int cnt, input bit v2,
                              output int code, output int res);
        code = 0; res = 0;
        if (kind == 0) begin
            if (op >= 8'h60 && op <= 8'h7F) code = 15;
            else if (op >= 8'h20 && op <= 8'h2F) code = 13;
            else if (op >= 8'h38 && op <= 8'h3F) code = 1;
            else res = 1;
        end else if (kind == 1) begin
            if (op >= 8'h40 && op <= 8'h5F) code = 14;
            else if (op <= 8'h0F) code = 2;
            else if (op >= 8'h30 && op <= 8'h37) code = 0;
            else if (op >= 8'h80) code = 16;
            else res = 1;
        end else if (kind == 2) begin
            if (op >= 8'h10 && op <= 8'h13) begin code = op & 31; if (v2) res = 5; end
            else res = 1;
        end else res = 1;
        if (kind != 2 && cnt >= 8) res = 1;
    endtask

    task automatic txn(input string etag, input int kind, input int op, input int sid,
                       input int addr, input int cnt, input logic [63:0] wd, input bit v2,
                       input int delay, input logic [2:0] ebits,
                       input logic [31:0] r0, input logic [31:0] r1);
        int code, res, j, lat, guard;
        bit tmo, ok;
        logic [31:0] e_cmd;
        int s_cmd, s_wd0, s_wd1, s_rd0, s_rd1, s_st, s_resp;
        expect_req(kind, op, cnt, v2, code, res);
        s_cmd = n_cmd; s_wd0 = n_wd0; s_wd1 = n_wd1; s_rd0 = n_rd0;
        s_rd1 = n_rd1; s_st = n_st; s_resp = n_resp;

        @(negedge clk);
        rsp_delay = delay; rsp_ebits = ebits; rsp_rd0 = r0; rsp_rd1 = r1;
        fmt_v2 = v2; req_kind = 2'(kind); req_opcode = 8'(op); req_sid = 4'(sid);
        req_addr = 16'(addr); req_cnt = 4'(cnt); req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (n_resp == s_resp && guard < 2000) begin @(posedge clk); guard++; end
        chk(etag, "response arrived", 64'(n_resp - s_resp), 64'd1);

        if (res != 0) begin
            chk(etag, "result", 64'(resp_e), 64'(res));
            chk("R1", "bus accesses on rejected request",
                64'((n_cmd-s_cmd)+(n_wd0-s_wd0)+(n_wd1-s_wd1)+(n_st-s_st)+(n_rd0-s_rd0)), 64'd0);
            return;
        end

        j   = (delay + GAP - 1) / GAP;
        tmo = (j > POLLS - 1);
        ok  = !tmo && (ebits == 3'b000);
        if (tmo)            res = 4;
        else if (ebits[1])  res = 2;
        else if (ebits[0] || ebits[2]) res = 3;
        else                res = 0;
        lat = 2 + (tmo ? (POLLS - 1) * GAP : j * GAP) + ((kind == 0 && ok) ? (cnt > 3 ? 2 : 1) : 0);

        if (kind == 2)  e_cmd = 32'(code << 27) | 32'(sid << 20);
        else if (!v2)   e_cmd = 32'(code << 27) | 32'(sid << 20) | 32'(addr << 4) | 32'(cnt & 7);
        else            e_cmd = 32'(code << 27) | 32'((addr & 255) << 4) | 32'(cnt & 7);

        chk(etag, "result", 64'(resp_e), 64'(res));
        chk(v2 ? "R5" : "R4", "command word", 64'(cmd_word), 64'(e_cmd));
        chk("R10", "command-to-response cycles", 64'(resp_cyc - cmd_cyc), 64'(lat));
        if (kind == 1) begin
            chk("R7", "data word 0", 64'(wd0), keep_bytes(wd, cnt) & 64'hFFFF_FFFF);
            chk("R7", "data word 1 count", 64'(n_wd1 - s_wd1), 64'(cnt > 3));
            if (cnt > 3) chk("R7", "data word 1", 64'(wd1), keep_bytes(wd, cnt) >> 32);
            chk("R8", "data written before command", 64'(wd_cyc < cmd_cyc), 64'd1);
        end
        if (kind == 0) begin
            chk("R7", "read bytes", resp_d, ok ? keep_bytes({r1, r0}, cnt) : 64'd0);
            chk("R8", "data fetches", 64'(n_rd0 - s_rd0), 64'(ok));
            if (ok) chk("R8", "fetch after command", 64'(rd0_cyc > cmd_cyc), 64'd1);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "ready after reset", 64'(req_ready), 64'd1);
        chk("R11", "no response after reset", 64'(resp_valid), 64'd0);
        chk("R11", "port idle after reset", 64'({bus_we, bus_re}), 64'd0);

        // opcode sweeps
        for (int op = 0; op < 256; op++) begin
            txn("R2", 0, op, 5, 16'h1234, 0, 64'h0, 1'b0, 0, 3'b000, 32'hA5, 32'h0);
            txn("R3", 1, op, 6, 16'hBEEF, 0, 64'h77, 1'b0, 0, 3'b000, 32'h0, 32'h0);
            txn("R6", 2, op, 9, 16'h0, 0, 64'h0, 1'b0, 0, 3'b000, 32'h0, 32'h0);
            txn("R6", 2, op, 9, 16'h0, 0, 64'h0, 1'b1, 0, 3'b000, 32'h0, 32'h0);
        end
        txn("R6", 3, 8'h60, 1, 16'h0, 0, 64'h0, 1'b0, 0, 3'b000, 32'h0, 32'h0);

        // length and layout sweep
        for (int v = 0; v < 2; v++)
            for (int c = 0; c < 16; c++) begin
                txn("R1", 0, 8'h70, 3, 16'hC3A5 + c, c, 64'h0, v[0], 1, 3'b000,
                    32'h4433_2211 ^ 32'(c), 32'h8877_6655);
                txn("R1", 1, 8'h45, 12, 16'h5A3C - c, c, 64'hF0E1_D2C3_B4A5_9687 + 64'(c),
                    v[0], 2, 3'b000, 32'h0, 32'h0);
            end

        // status value and completion delay sweep
        for (int e = 0; e < 8; e++)
            for (int d = 0; d <= (POLLS - 1) * GAP + 2; d++) begin
                txn("R9", 0, 8'h3A, 2, 16'h0310, 5, 64'h0, 1'b0, d, 3'(e),
                    32'h1357_9BDF, 32'h2468_ACE0);
                txn("R9", 1, 8'h31, 2, 16'h0311, 1, 64'hAB, 1'b1, d, 3'(e), 32'h0, 32'h0);
                txn("R10", 2, 8'h12, 4, 16'h0, 0, 64'h0, 1'b0, d, 3'(e), 32'h0, 32'h0);
            end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule